// File: doc/BRIEF.md
# Doorbell and Window Write Translator

This block sits behind one aperture that two kinds of traffic share. The low part of the aperture is divided into doorbell slots of equal size. Each slot belongs to one doorbell. A write that lands in a slot becomes an outbound interrupt write. The address of that write is the target the far host programmed for the doorbell, and its data is the payload word stored for the doorbell. The value the host wrote is discarded. Slots may share a target address, and the logic handles that case exactly like distinct targets. This is why hosts that use a single interrupt address and hosts that use one address per vector are served by the same path.

A write at or above the window-1 offset is a window access. It is forwarded with its address rebased: the window base plus the distance from the window-1 offset. A request that cannot be served is dropped, and one of two sticky error flags is set. This happens when the doorbell index is out of range, when a doorbell has not been configured, when a window access falls outside the window, or when the window has not been configured.

The command block supplies the configuration: the doorbell count, the slot stride as a power of two, and the window offset, base and size. It also fills the per-doorbell table of targets and payloads through a simple write port. The outbound side uses a valid/ready handshake, and only one request is handled at a time.

Top module: `dbwin_xlate`

## Requirements
- R1: After reset, `out_valid` is 0, `req_ready` is 1, and both `err_db` and `err_mw` are 0.
- R2: A request with `req_ofs < cfg_mw_ofs` is a doorbell write for index `req_ofs >> cfg_db_shift`. When it is served, `out_valid` rises one cycle after the cycle that follows acceptance. `out_kind` is 1, and `out_addr` is the target stored for that index.
- R3: The `out_data` of a served doorbell write is the payload stored for that index, never `req_data`.
- R4: Two doorbell indices whose stored targets are equal each produce their own outbound write, with their own payload and with the same timing as any other doorbell.
- R5: A doorbell write whose index is at least `cfg_db_count` (or at least the table depth) is dropped, with no outbound write, and sets `err_db`. `err_db` stays set until reset.
- R6: A doorbell write while `cfg_db_en` is 0 is dropped and sets `err_db`.
- R7: A request with `req_ofs >= cfg_mw_ofs`, with `cfg_mw_en` set and with `req_ofs - cfg_mw_ofs < cfg_mw_size`, raises `out_valid` in the cycle after acceptance. In that case `out_kind` is 0, `out_addr` equals `cfg_mw_base + (req_ofs - cfg_mw_ofs)` and `out_data` equals `req_data`.
- R8: A window request at or beyond the window size, or one made while `cfg_mw_en` is 0, is dropped and sets `err_mw`. `err_mw` stays set until reset.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_addr`, `out_data` and `out_kind` hold their values.
- R10: `req_ready` is 0 from the acceptance of a served request until its outbound write is taken. A dropped request leaves `req_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Incoming write request valid |
| req_ready | output | 1 | Block can accept a request |
| req_ofs | input | OFS_W | Byte offset of the write within the aperture |
| req_data | input | DATA_W | Data written by the host |
| cfg_db_en | input | 1 | Doorbell targets have been configured |
| cfg_db_count | input | CNT_W | Number of doorbells in use |
| cfg_db_shift | input | SH_W | Log2 of the doorbell slot stride in bytes |
| cfg_mw_en | input | 1 | Window translation has been configured |
| cfg_mw_ofs | input | OFS_W | Offset where window 1 starts in the aperture |
| cfg_mw_base | input | ADDR_W | Outbound base address of window 1 |
| cfg_mw_size | input | OFS_W | Window 1 size in bytes |
| tbl_we | input | 1 | Write strobe for the doorbell table |
| tbl_idx | input | IDX_W | Doorbell table entry to write |
| tbl_addr | input | ADDR_W | Interrupt target address for that entry |
| tbl_data | input | DATA_W | Interrupt payload for that entry |
| out_valid | output | 1 | Outbound write valid |
| out_ready | input | 1 | Outbound write accepted |
| out_addr | output | ADDR_W | Outbound write address |
| out_data | output | DATA_W | Outbound write data |
| out_kind | output | 1 | 1 = doorbell interrupt write, 0 = window write |
| err_db | output | 1 | Sticky: a doorbell write was dropped |
| err_mw | output | 1 | Sticky: a window write was dropped |

## Verification
The assertions assume that the configuration inputs stay constant from the acceptance of a request until the cycle after it. They also assume that the doorbell table is not written while a lookup is pending. Under these assumptions the cycle-after checks on error flags and window addresses compare against the values the request was decoded with. The stimulus enforces this: it sets the configuration and fills the table only when the block is idle and no request is pending. It then issues one request at a time, either directed at slot edges, shared targets and window limits, or drawn at random across both parts of the aperture and past its end.

// File: rtl/dbwin_pkg.sv
package dbwin_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_SEND} st_e;
  typedef enum logic [1:0] {CL_DB, CL_WIN, CL_DBERR, CL_WINERR} cls_e;
endpackage

// File: rtl/dbwin_decode.sv
module dbwin_decode
  import dbwin_pkg::*;
#(
  parameter int OFS_W  = 32,
  parameter int ADDR_W = 64,
  parameter int NUM_DB = 32,
  parameter int IDX_W  = $clog2(NUM_DB),
  parameter int CNT_W  = $clog2(NUM_DB + 1),
  parameter int SH_W   = $clog2(OFS_W)
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic              db_en,
  input  logic [CNT_W-1:0]  db_count,
  input  logic [SH_W-1:0]   db_shift,
  input  logic              mw_en,
  input  logic [OFS_W-1:0]  mw_ofs,
  input  logic [ADDR_W-1:0] mw_base,
  input  logic [OFS_W-1:0]  mw_size,
  output cls_e              cls,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] win_addr
);
  localparam logic [OFS_W-1:0] DEPTH_LIM = OFS_W'(NUM_DB);

  logic [OFS_W-1:0] slot;
  logic [OFS_W-1:0] rel;
  logic             in_db;
  logic             slot_ok;
  logic             win_ok;

  always_comb begin
    in_db    = ofs < mw_ofs;
    slot     = ofs >> db_shift;
    rel      = ofs - mw_ofs;
    slot_ok  = db_en && (slot < OFS_W'(db_count)) && (slot < DEPTH_LIM);
    win_ok   = mw_en && (rel < mw_size);
    idx      = slot[IDX_W-1:0];
    win_addr = mw_base + ADDR_W'(rel);
    if (in_db) cls = slot_ok ? CL_DB  : CL_DBERR;
    else       cls = win_ok  ? CL_WIN : CL_WINERR;
  end
endmodule

// File: rtl/dbwin_tbl.sv
module dbwin_tbl #(
  parameter int W     = 96,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dbwin_xlate.sv
module dbwin_xlate
  import dbwin_pkg::*;
#(
  parameter int OFS_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 64,
  parameter int NUM_DB = 32,
  parameter int IDX_W  = $clog2(NUM_DB),
  parameter int CNT_W  = $clog2(NUM_DB + 1),
  parameter int SH_W   = $clog2(OFS_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [DATA_W-1:0] req_data,
  input  logic              cfg_db_en,
  input  logic [CNT_W-1:0]  cfg_db_count,
  input  logic [SH_W-1:0]   cfg_db_shift,
  input  logic              cfg_mw_en,
  input  logic [OFS_W-1:0]  cfg_mw_ofs,
  input  logic [ADDR_W-1:0] cfg_mw_base,
  input  logic [OFS_W-1:0]  cfg_mw_size,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [DATA_W-1:0] tbl_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              out_kind,
  output logic              err_db,
  output logic              err_mw
);
  localparam int ENT_W = ADDR_W + DATA_W;

  st_e               st;
  cls_e              dec_cls;
  logic [IDX_W-1:0]  dec_idx;
  logic [ADDR_W-1:0] dec_waddr;
  logic [ENT_W-1:0]  ent_rd;
  logic              accept;

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && (st == ST_IDLE);

  dbwin_decode #(
    .OFS_W(OFS_W), .ADDR_W(ADDR_W), .NUM_DB(NUM_DB),
    .IDX_W(IDX_W), .CNT_W(CNT_W), .SH_W(SH_W)
  ) dec_i (
    .ofs      (req_ofs),
    .db_en    (cfg_db_en),
    .db_count (cfg_db_count),
    .db_shift (cfg_db_shift),
    .mw_en    (cfg_mw_en),
    .mw_ofs   (cfg_mw_ofs),
    .mw_base  (cfg_mw_base),
    .mw_size  (cfg_mw_size),
    .cls      (dec_cls),
    .idx      (dec_idx),
    .win_addr (dec_waddr)
  );

  dbwin_tbl #(.W(ENT_W), .DEPTH(NUM_DB), .AW(IDX_W)) tbl_i (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_idx),
    .wdata ({tbl_addr, tbl_data}),
    .re    (accept),
    .raddr (dec_idx),
    .rdata (ent_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_data  <= '0;
      out_kind  <= 1'b0;
      err_db    <= 1'b0;
      err_mw    <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            case (dec_cls)
              CL_DB:    st <= ST_LOOK;
              CL_WIN: begin
                out_valid <= 1'b1;
                out_kind  <= 1'b0;
                out_addr  <= dec_waddr;
                out_data  <= req_data;
                st        <= ST_SEND;
              end
              CL_DBERR:  err_db <= 1'b1;
              default:   err_mw <= 1'b1;
            endcase
          end
        end
        ST_LOOK: begin
          out_valid <= 1'b1;
          out_kind  <= 1'b1;
          out_addr  <= ent_rd[ENT_W-1:DATA_W];
          out_data  <= ent_rd[DATA_W-1:0];
          st        <= ST_SEND;
        end
        default: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            st        <= ST_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dbwin_xlate_chk.sv
module dbwin_xlate_chk #(
  parameter int OFS_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 64,
  parameter int CNT_W  = 6,
  parameter int SH_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [OFS_W-1:0]  req_ofs,
  input logic [DATA_W-1:0] req_data,
  input logic              cfg_db_en,
  input logic [CNT_W-1:0]  cfg_db_count,
  input logic [SH_W-1:0]   cfg_db_shift,
  input logic              cfg_mw_en,
  input logic [OFS_W-1:0]  cfg_mw_ofs,
  input logic [ADDR_W-1:0] cfg_mw_base,
  input logic [OFS_W-1:0]  cfg_mw_size,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [DATA_W-1:0] out_data,
  input logic              out_kind,
  input logic              err_db,
  input logic              err_mw
);
  logic             acc;
  logic             in_db;
  logic [OFS_W-1:0] rel;
  assign acc   = req_valid && req_ready;
  assign in_db = req_ofs < cfg_mw_ofs;
  assign rel   = req_ofs - cfg_mw_ofs;

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && req_ready && !err_db && !err_mw));

  p_db_range_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && in_db && cfg_db_en && ((req_ofs >> cfg_db_shift) >= OFS_W'(cfg_db_count)))
      |=> (err_db && !out_valid));

  p_db_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    err_db |=> err_db);

  p_db_unconf_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && in_db && !cfg_db_en) |=> (err_db && !out_valid));

  p_win_xlate_r7: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_db && cfg_mw_en && (rel < cfg_mw_size))
      |=> (out_valid && !out_kind && out_data == $past(req_data)
           && out_addr == $past(cfg_mw_base) + ADDR_W'($past(req_ofs) - $past(cfg_mw_ofs))));

  p_win_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && !in_db && (!cfg_mw_en || rel >= cfg_mw_size)) |=> (err_mw && !out_valid));

  p_mw_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_mw |=> err_mw);

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready)
      |=> (out_valid && $stable(out_addr) && $stable(out_data) && $stable(out_kind)));

  p_single_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !req_ready);
endmodule

bind dbwin_xlate dbwin_xlate_chk #(
  .OFS_W(OFS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .SH_W(SH_W)
) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_ofs(req_ofs), .req_data(req_data), .cfg_db_en(cfg_db_en),
  .cfg_db_count(cfg_db_count), .cfg_db_shift(cfg_db_shift),
  .cfg_mw_en(cfg_mw_en), .cfg_mw_ofs(cfg_mw_ofs), .cfg_mw_base(cfg_mw_base),
  .cfg_mw_size(cfg_mw_size), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_data(out_data), .out_kind(out_kind),
  .err_db(err_db), .err_mw(err_mw)
);

// File: tb/dbwin_xlate_tb_top.sv
`timescale 1ns/1ps
module dbwin_xlate_tb_top;
  localparam int OFS_W = 32, DATA_W = 32, ADDR_W = 64, NUM_DB = 32;
  localparam int IDX_W = 5, CNT_W = 6, SH_W = 5;
  localparam logic [SH_W-1:0]   SHIFT = 5'd3;
  localparam logic [CNT_W-1:0]  COUNT = 6'd20;
  localparam logic [OFS_W-1:0]  MWO   = 32'h100;
  localparam logic [OFS_W-1:0]  MWS   = 32'h1000;
  localparam logic [ADDR_W-1:0] MWB   = 64'h0000_0040_0000_0000;

  logic clk = 0;
  logic rst = 1;
  logic req_valid = 0, req_ready;
  logic [OFS_W-1:0] req_ofs = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic cfg_db_en = 0, cfg_mw_en = 0;
  logic tbl_we = 0;
  logic [IDX_W-1:0] tbl_idx = '0;
  logic [ADDR_W-1:0] tbl_addr = '0;
  logic [DATA_W-1:0] tbl_data = '0;
  logic out_valid, out_ready = 0, out_kind, err_db, err_mw;
  logic [ADDR_W-1:0] out_addr;
  logic [DATA_W-1:0] out_data;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_err_db = 0, m_err_mw = 0;

  always #4 clk = ~clk;

  dbwin_xlate #(.OFS_W(OFS_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_DB(NUM_DB))
  dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_ofs(req_ofs), .req_data(req_data), .cfg_db_en(cfg_db_en),
    .cfg_db_count(COUNT), .cfg_db_shift(SHIFT), .cfg_mw_en(cfg_mw_en),
    .cfg_mw_ofs(MWO), .cfg_mw_base(MWB), .cfg_mw_size(MWS),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .out_kind(out_kind), .err_db(err_db), .err_mw(err_mw)
  );

  function automatic logic [ADDR_W-1:0] tgt_of(int i);
    return (i % 2 == 0) ? 64'h0000_0000_FEE0_0000 : 64'h0000_0001_0000_0000 + 64'(i * 64);
  endfunction

  function automatic logic [DATA_W-1:0] pay_of(int i);
    return 32'hD000_0000 + 32'(i * 7);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; cfg_db_en = 0; cfg_mw_en = 0;
    m_err_db = 0; m_err_mw = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 out_valid", 64'(out_valid), 64'd0);
    chk("R1 req_ready", 64'(req_ready), 64'd1);
    chk("R1 err_db", 64'(err_db), 64'd0);
    chk("R1 err_mw", 64'(err_mw), 64'd0);
  endtask

  task automatic run_req(logic [OFS_W-1:0] ofs, logic [DATA_W-1:0] d, int hold, string tag);
    bit in_db, ok;
    int idx;
    logic [OFS_W-1:0] rel;
    logic [ADDR_W-1:0] ea;
    logic [DATA_W-1:0] ed;
    in_db = ofs < MWO;
    idx = int'(ofs >> SHIFT);
    rel = ofs - MWO;
    if (in_db) begin
      ok = cfg_db_en && (idx < int'(COUNT));
      ea = tgt_of(idx); ed = pay_of(idx);
    end else begin
      ok = cfg_mw_en && (rel < MWS);
      ea = MWB + 64'(rel); ed = d;
    end
    @(negedge clk);
    chk({tag, " R10 ready before"}, 64'(req_ready), 64'd1);
    req_ofs = ofs; req_data = d; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (!ok) begin
      if (in_db) m_err_db = 1; else m_err_mw = 1;
      chk({tag, " R5/R6/R8 no output"}, 64'(out_valid), 64'd0);
      chk({tag, " R5/R6 err_db"}, 64'(err_db), 64'(m_err_db));
      chk({tag, " R8 err_mw"}, 64'(err_mw), 64'(m_err_mw));
      chk({tag, " R10 ready after drop"}, 64'(req_ready), 64'd1);
    end else begin
      if (in_db) begin
        chk({tag, " R2 lookup cycle"}, 64'(out_valid), 64'd0);
        chk({tag, " R10 busy"}, 64'(req_ready), 64'd0);
        @(negedge clk);
      end
      chk({tag, " R2/R7 valid"}, 64'(out_valid), 64'd1);
      chk({tag, " R2/R7 kind"}, 64'(out_kind), 64'(in_db));
      chk({tag, " R2/R7 addr"}, out_addr, ea);
      chk({tag, " R3/R7 data"}, 64'(out_data), 64'(ed));
      for (int k = 0; k < hold; k++) begin
        @(negedge clk);
        chk({tag, " R9 hold valid"}, 64'(out_valid), 64'd1);
        chk({tag, " R9 hold addr"}, out_addr, ea);
        chk({tag, " R9 hold data"}, 64'(out_data), 64'(ed));
        chk({tag, " R10 busy hold"}, 64'(req_ready), 64'd0);
      end
      out_ready = 1;
      @(negedge clk);
      out_ready = 0;
      chk({tag, " R10 taken"}, 64'(out_valid), 64'd0);
      chk({tag, " R10 ready again"}, 64'(req_ready), 64'd1);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R6: doorbell before configuration; R8: window before configuration
    run_req(32'h8, 32'h1111_1111, 0, "R6 unconfigured db");
    run_req(MWO + 32'h10, 32'h2222_2222, 0, "R8 unconfigured window");
    do_reset();
    for (int i = 0; i < NUM_DB; i++) begin
      @(negedge clk);
      tbl_we = 1; tbl_idx = IDX_W'(i); tbl_addr = tgt_of(i); tbl_data = pay_of(i);
    end
    @(negedge clk); tbl_we = 0;
    cfg_db_en = 1; cfg_mw_en = 1;
    run_req(32'h0, 32'hAAAA_AAAA, 0, "R2 slot0");
    run_req(32'h7, 32'hBBBB_BBBB, 0, "R3 slot0 unaligned");
    run_req(32'h98, 32'hCCCC_CCCC, 0, "R2 last slot 19");
    run_req(32'h10, 32'h0, 0, "R4 shared slot2");
    run_req(32'h20, 32'h0, 2, "R4 shared slot4");
    run_req(MWO, 32'h1234_5678, 0, "R7 window start");
    run_req(MWO + MWS - 1, 32'h8765_4321, 3, "R9 window end held");
    run_req(32'hA0, 32'hDEAD_BEEF, 0, "R5 index equals count");
    run_req(32'hF8, 32'hDEAD_BEEF, 0, "R5 top slot");
    run_req(MWO + MWS, 32'hFEED_0000, 0, "R8 window past size");
    for (int n = 0; n < 300; n++) begin
      run_req($urandom_range(32'h1200, 0), $urandom(), int'($urandom_range(2, 0)), "rand R2/R7");
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule